// File: doc/BRIEF.md
# Key-locked peripheral reset controller

This register block lets firmware pulse the reset of individual peripheral blocks, up to 160 of them. Each peripheral owns one bit in a bank of 32-bit reset-trigger registers. Writing a 1 to that bit drives the peripheral's reset output high for a fixed number of clocks, the same reset the peripheral sees at chip reset. The bit then clears by itself. Trigger writes are protected by a 32-bit key. The trigger bank accepts writes only after firmware has written the exact unlock key to the lock register. Any other value written there locks the bank again.

The block also generates the host-domain reset. An internal host reset is raised by any of three sources: the system reset input, a missing second power-good input, or a firmware force bit. A select bit routes either this internal reset or an external platform reset input to the host reset output. A status register reports whether the internal host reset is currently active.

Registers sit on a simple word-addressed bus with a write strobe and a combinational read port.

Top module: `periph_reset_ctrl`

## Requirements
- R1: After power-on reset the block reads as locked, every `periph_rst` bit is low, the host control register reads 0, and `host_rst` follows `plat_rst_in`.
- R2: Writing 0xA6382D4C to the lock register (address 0x0) unlocks the trigger bank from the next cycle. Bit 0 of the lock register reads 1 when locked and 0 when unlocked.
- R3: Writing any other value to the lock register locks the bank. This includes the neighbouring value 0xA6382D4D.
- R4: While the bank is locked, writes to the trigger registers are ignored. No `periph_rst` bit rises and the registers read back 0.
- R5: Peripheral n is triggered through the register at address 1 + n/32, bit n%32. Five registers (addresses 0x1 to 0x5) cover peripherals 0 to 159.
- R6: Each 1 in an accepted trigger write raises the matching `periph_rst` bit from the clock edge that takes the write. The bit stays high for exactly 4 clocks and then clears. Bits written as 0 have no effect.
- R7: Reading a trigger register returns the reset pulses still in progress for its 32 peripherals.
- R8: The internal host reset is registered one clock after its sources. It is active when `sys_rst_in` is high, or `pwr_good2` is low, or the force bit is set.
- R9: Bit 0 of the status register (address 0xF) reads 0 while the internal host reset is active and 1 while it is inactive.
- R10: The host control register (address 0xE) holds the force bit in bit 0 and the select bit in bit 1, and reads back what was written. With select 1, `host_rst` follows the internal host reset. With select 0, it follows `plat_rst_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| sys_rst_in | input | 1 | System reset source, active high |
| pwr_good2 | input | 1 | Second power-good input, low means power is bad |
| plat_rst_in | input | 1 | External platform reset, active high |
| periph_rst | output | 160 | Per-peripheral reset pulses, active high |
| host_rst | output | 1 | Selected host-domain reset, active high |

## Verification
The trigger bank is exercised with several kinds of write:
- Sparse bit patterns in the lowest register confirm that only written ones pulse.
- Single bits in a middle register and in the top register tell a correct ID-to-bit mapping apart from an off-by-one register or bit index.
- An all-ones write while locked, and writes after the neighbouring lock value or an arbitrary value, separate true key matching from matching on a partial key.
- Each host reset source is raised alone, with select set both ways. A fault in one OR term or in the output mux then shows up on its own.

// File: rtl/prc_pkg.sv
package prc_pkg;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'hA638_2D4C;
    localparam logic [ADDR_W-1:0] ADDR_LOCK    = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_HOSTCTL = 4'hE;
    localparam logic [ADDR_W-1:0] ADDR_STATUS  = 4'hF;

    typedef struct packed {
        logic sel_internal;
        logic force_on;
    } host_ctl_t;
endpackage

// File: rtl/prc_key_lock.sv
module prc_key_lock
    import prc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lock,
    input  logic [WORD_W-1:0] wdata,
    output logic              locked
);
    typedef struct packed {
        logic locked;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lock) begin
            st_d.locked = (wdata != UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{locked: 1'b1};
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;

    // R2
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && wdata == UNLOCK_KEY) |=> !locked);
    // R3
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && wdata != UNLOCK_KEY) |=> locked);
endmodule

// File: rtl/prc_pulse_bank.sv
module prc_pulse_bank #(
    parameter int unsigned NUM_PERIPH = 160,
    parameter int unsigned PULSE_LEN  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] fire,
    output logic [NUM_PERIPH-1:0] active
);
    localparam int unsigned CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

    typedef struct packed {
        logic [NUM_PERIPH-1:0]         on;
        logic [NUM_PERIPH-1:0][CW-1:0] cnt;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if (fire[i]) begin
                bk_d.on[i]  = 1'b1;
                bk_d.cnt[i] = CW'(PULSE_LEN - 1);
            end else if (bk_q.on[i]) begin
                if (bk_q.cnt[i] == '0) bk_d.on[i] = 1'b0;
                else                   bk_d.cnt[i] = bk_q.cnt[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign active = bk_q.on;

    // R6
    fire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> ((active & $past(fire)) == $past(fire)));
endmodule

// File: rtl/prc_host_reset.sv
module prc_host_reset
    import prc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sys_rst_in,
    input  logic      pwr_good2,
    input  logic      plat_rst_in,
    input  host_ctl_t ctl,
    output logic      int_rst,
    output logic      host_rst
);
    typedef struct packed {
        logic int_rst;
    } host_state_t;

    host_state_t hs_d, hs_q;

    always_comb begin
        hs_d.int_rst = sys_rst_in | ~pwr_good2 | ctl.force_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '{int_rst: 1'b1};
        else        hs_q <= hs_d;
    end

    assign int_rst  = hs_q.int_rst;
    assign host_rst = ctl.sel_internal ? hs_q.int_rst : plat_rst_in;

    // R8
    host_src_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_in || !pwr_good2 || ctl.force_on) |=> int_rst);
    // R8
    host_src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst_in && pwr_good2 && !ctl.force_on) |=> !int_rst);
endmodule

// File: rtl/periph_reset_ctrl.sv
module periph_reset_ctrl
    import prc_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 160,
    parameter int unsigned PULSE_LEN  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [3:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  sys_rst_in,
    input  logic                  pwr_good2,
    input  logic                  plat_rst_in,
    output logic [NUM_PERIPH-1:0] periph_rst,
    output logic                  host_rst
);
    localparam int unsigned NUM_REGS = (NUM_PERIPH + WORD_W - 1) / WORD_W;
    localparam int unsigned PAD_W    = NUM_REGS * WORD_W;

    typedef struct packed {
        host_ctl_t ctl;
    } top_regs_t;

    top_regs_t rg_d, rg_q;
    logic locked;
    logic int_rst;
    logic [PAD_W-1:0] fire_pad;
    logic [PAD_W-1:0] active_pad;
    logic [NUM_PERIPH-1:0] fire;

    prc_key_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lock(bus_we && bus_addr == ADDR_LOCK),
        .wdata  (bus_wdata),
        .locked (locked)
    );

    always_comb begin
        fire_pad = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (bus_we && !locked && bus_addr == ADDR_W'(k + 1))
                fire_pad[k*WORD_W +: WORD_W] = bus_wdata;
        end
    end
    assign fire = fire_pad[NUM_PERIPH-1:0];

    prc_pulse_bank #(.NUM_PERIPH(NUM_PERIPH), .PULSE_LEN(PULSE_LEN)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .active(periph_rst)
    );

    always_comb begin
        rg_d = rg_q;
        if (bus_we && bus_addr == ADDR_HOSTCTL) rg_d.ctl = host_ctl_t'(bus_wdata[1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    prc_host_reset u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_rst_in (sys_rst_in),
        .pwr_good2  (pwr_good2),
        .plat_rst_in(plat_rst_in),
        .ctl        (rg_q.ctl),
        .int_rst    (int_rst),
        .host_rst   (host_rst)
    );

    always_comb begin
        active_pad = '0;
        active_pad[NUM_PERIPH-1:0] = periph_rst;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_LOCK:    bus_rdata[0]   = locked;
            ADDR_HOSTCTL: bus_rdata[1:0] = rg_q.ctl;
            ADDR_STATUS:  bus_rdata[0]   = ~int_rst;
            default: begin
                for (int k = 0; k < NUM_REGS; k++) begin
                    if (bus_addr == ADDR_W'(k + 1))
                        bus_rdata = active_pad[k*WORD_W +: WORD_W];
                end
            end
        endcase
    end

    // Pulse-length watch on peripheral 0
    logic [7:0] chk_len0;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             chk_len0 <= '0;
        else if (fire[0])       chk_len0 <= 8'd1;
        else if (periph_rst[0]) chk_len0 <= (chk_len0 == 8'hFF) ? chk_len0 : chk_len0 + 8'd1;
        else                    chk_len0 <= '0;
    end

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst[0] |-> (chk_len0 != 0 && chk_len0 <= 8'(PULSE_LEN)));
    // R4
    locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(periph_rst & ~$past(periph_rst))) |-> $past(bus_we && !locked));
endmodule

// File: tb/tb_periph_reset_ctrl.sv
module tb_periph_reset_ctrl;
    localparam int NP = 160;
    localparam int PL = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          bus_we;
    logic [3:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          sys_rst_in, pwr_good2, plat_rst_in;
    logic [NP-1:0] periph_rst;
    logic          host_rst;

    periph_reset_ctrl #(.NUM_PERIPH(NP), .PULSE_LEN(PL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_in(sys_rst_in),
        .pwr_good2(pwr_good2), .plat_rst_in(plat_rst_in),
        .periph_rst(periph_rst), .host_rst(host_rst)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            at;
        logic [NP-1:0] exp;
        string         req;
    } item_t;
    item_t sb[$];

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares periph_rst with the queued expectations
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            item_t it;
            it = sb.pop_front();
            check(it.req, periph_rst, it.exp);
        end
    end

    function automatic logic [NP-1:0] reg_mask(input int a, input logic [31:0] d);
        logic [NP-1:0] m;
        m = '0;
        for (int b = 0; b < 32; b++) begin
            if (d[b] && (32*(a-1) + b) < NP) m[32*(a-1) + b] = 1'b1;
        end
        return m;
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // driver: trigger write plus expected pulse items
    task automatic trig_write(input int a, input logic [31:0] d, input logic [NP-1:0] exp, input string req);
        int k;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(posedge clk);
        #1;
        k = cyc;
        for (int j = 0; j < PL; j++) sb.push_back('{at: k + j, exp: exp, req: req});
        sb.push_back('{at: k + PL, exp: '0, req: req});
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [NP-1:0] m;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        sys_rst_in = 1'b0; pwr_good2 = 1'b1; plat_rst_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(4'h0, rd); check("R1 lock after reset", NP'(rd), NP'(1));
        bus_read(4'hE, rd); check("R1 hostctl after reset", NP'(rd), '0);
        check("R1 periph_rst after reset", periph_rst, '0);
        check("R1 host_rst follows plat", NP'(host_rst), '0);

        // R4 locked writes ignored
        trig_write(1, 32'hFFFF_FFFF, '0, "R4 locked write");
        bus_read(4'h1, rd); check("R4 locked readback", NP'(rd), '0);
        drain();

        // R2 unlock
        bus_write(4'h0, 32'hA638_2D4C);
        bus_read(4'h0, rd); check("R2 unlocked readback", NP'(rd), '0);

        // R6 sparse pattern, R7 readback during pulse
        trig_write(1, 32'h0000_0005, reg_mask(1, 32'h5), "R6 sparse pulse");
        bus_read(4'h1, rd); check("R7 readback in progress", NP'(rd), NP'(32'h5));
        drain();
        bus_read(4'h1, rd); check("R6 self-clear readback", NP'(rd), '0);

        // R5 mapping: id 159 and id 68
        m = '0; m[159] = 1'b1;
        trig_write(5, 32'h8000_0000, m, "R5 id 159");
        drain();
        m = '0; m[68] = 1'b1;
        trig_write(3, 32'h0000_0010, m, "R5 id 68");
        bus_read(4'h3, rd); check("R7 readback reg 3", NP'(rd), NP'(32'h10));
        drain();

        // R3 neighbour key locks
        bus_write(4'h0, 32'hA638_2D4D);
        bus_read(4'h0, rd); check("R3 neighbour key locks", NP'(rd), NP'(1));
        trig_write(2, 32'h0000_FFFF, '0, "R4 write after relock");
        drain();
        bus_write(4'h0, 32'hA638_2D4C);
        bus_write(4'h0, 32'h1234_5678);
        bus_read(4'h0, rd); check("R3 arbitrary value locks", NP'(rd), NP'(1));
        trig_write(4, 32'h0000_0001, '0, "R4 write after arbitrary lock");
        drain();

        // R10 platform path
        plat_rst_in = 1'b1; settle();
        check("R10 sel0 follows plat", NP'(host_rst), NP'(1));
        bus_read(4'hF, rd); check("R9 status inactive", NP'(rd), NP'(1));

        // R8 force, R10 internal select
        bus_write(4'hE, 32'h3); settle();
        bus_read(4'hE, rd); check("R10 hostctl readback", NP'(rd), NP'(3));
        plat_rst_in = 1'b0; settle();
        check("R8 force asserts host_rst", NP'(host_rst), NP'(1));
        bus_read(4'hF, rd); check("R9 status active", NP'(rd), '0);
        bus_write(4'hE, 32'h2); settle();
        check("R8 no source host_rst low", NP'(host_rst), '0);
        sys_rst_in = 1'b1; settle();
        check("R8 sys_rst_in asserts", NP'(host_rst), NP'(1));
        sys_rst_in = 1'b0; pwr_good2 = 1'b0; settle();
        check("R8 pwr_good2 low asserts", NP'(host_rst), NP'(1));
        bus_read(4'hF, rd); check("R9 status on power fail", NP'(rd), '0);
        bus_write(4'hE, 32'h0); settle();
        check("R10 sel0 ignores internal", NP'(host_rst), '0);
        pwr_good2 = 1'b1; settle();
        bus_read(4'hF, rd); check("R9 status recovered", NP'(rd), NP'(1));

        drain();
        summary();
        $finish;
    end
endmodule